// File: doc/BRIEF.md
# Four-Function Arithmetic/Logic Unit with Condition Flags

This block is the combinational arithmetic/logic stage of a small 32-bit processor. It takes two operand words, `a_i` and `b_i`, and a 4-bit operation selector. It returns a result word together with three condition indications: a zero indication, an unsigned carry/borrow indication and a signed overflow indication. The four operations are addition, subtraction, bitwise AND and bitwise XOR. Subtraction takes the first operand away from the second, so the result is `b_i - a_i`.

The block has no clock and holds no state. A register elsewhere in the processor latches the flags when an instruction retires. Selector values outside the four defined operations give an all-zero result with every flag low, and they raise `bad_fn_o` so that the decoder or an exception path can react.

Top module: `alu4_core`

## Requirements
- R1: The outputs are a pure function of `a_i`, `b_i` and `fn_i`. They settle after an input change with no clock edge involved.
- R2: Selector 0 gives `res_o = a_i + b_i` modulo 2^32.
- R3: Selector 1 gives `res_o = b_i - a_i` modulo 2^32.
- R4: Selector 2 gives `res_o = a_i & b_i`.
- R5: Selector 3 gives `res_o = a_i ^ b_i`.
- R6: `zf_o` is 1 exactly when all 32 bits of `res_o` are 0, for every selector.
- R7: For selector 0, `cf_o` is the carry out of bit 31. For selector 1, `cf_o` is 1 when `b_i < a_i` as unsigned numbers (a borrow).
- R8: For selector 0, `of_o` is 1 when `a_i` and `b_i` have the same sign and `res_o` has the other sign. For selector 1, `of_o` is 1 when `a_i` and `b_i` differ in sign and the sign of `res_o` differs from that of `b_i`.
- R9: For selectors 2 and 3, `cf_o` and `of_o` are 0.
- R10: Selectors 4 to 15 give `res_o = 0` and `cf_o = of_o = 0`, and raise `bad_fn_o` to 1. Because the result is 0, `zf_o` is 1. `bad_fn_o` is 0 for selectors 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand (the subtrahend for selector 1) |
| b_i | input | 32 | Second operand (the minuend for selector 1) |
| fn_i | input | 4 | Operation selector: 0 add, 1 subtract, 2 AND, 3 XOR |
| res_o | output | 32 | Result word |
| zf_o | output | 1 | Result is all zeros |
| cf_o | output | 1 | Carry out (add) or borrow (subtract) |
| of_o | output | 1 | Signed overflow |
| bad_fn_o | output | 1 | Selector is not one of the four operations |

## Verification
Every output is due in the same simulation time step as the input change that causes it, so the latency is zero cycles. The bench applies a new operand/selector triple and waits 1 ns, with no clock edge in between. Only then does it sample, which confirms that no register lies on any path. The sweep covers all 16 selectors against a grid of corner operands: zero, one, all-ones, the sign boundary values and equal pairs. It then repeats with random operand pairs. The expected values come from 34-bit signed and 33-bit unsigned arithmetic in the bench.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned FN_W   = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic ovf;
  } alu_flags_t;

endpackage

// File: rtl/alu4_arith.sv
module alu4_arith #(
  parameter int unsigned W = alu4_pkg::WORD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  // Extended-width add; for subtract, b + ~a + 1 with the carry inverted into a borrow.
  function automatic logic [W:0] ext_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic sign_ovf(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  logic [W-1:0] op_x;
  logic [W-1:0] op_y;
  logic [W:0]   full;

  assign op_x  = b_i;
  assign op_y  = sub_i ? ~a_i : a_i;
  assign full  = ext_add(op_x, op_y, sub_i);
  assign sum_o = full[W-1:0];

  // Borrow is the inverted carry of the two's-complement add.
  assign carry_o = sub_i ? ~full[W] : full[W];
  assign ovf_o   = sign_ovf(op_x[W-1], op_y[W-1], full[W-1]);

endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
  parameter int unsigned W = alu4_pkg::WORD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         xor_i,
  output logic [W-1:0] out_o
);

  logic [W-1:0] and_w;
  logic [W-1:0] xor_w;

  assign and_w = a_i & b_i;
  assign xor_w = a_i ^ b_i;
  assign out_o = xor_i ? xor_w : and_w;

endmodule

// File: rtl/alu4_select.sv
module alu4_select #(
  parameter int unsigned W    = alu4_pkg::WORD_W,
  parameter int unsigned FW   = alu4_pkg::FN_W
) (
  input  logic [FW-1:0]         fn_i,
  input  logic [W-1:0]          sum_i,
  input  logic                  carry_i,
  input  logic                  ovf_i,
  input  logic [W-1:0]          bits_i,
  output logic [W-1:0]          res_o,
  output alu4_pkg::alu_flags_t  flags_o,
  output logic                  bad_fn_o
);
  import alu4_pkg::*;

  always_comb begin
    res_o         = '0;
    flags_o.carry = 1'b0;
    flags_o.ovf   = 1'b0;
    bad_fn_o      = 1'b0;
    case (fn_i)
      FN_ADD, FN_SUB: begin
        res_o         = sum_i;
        flags_o.carry = carry_i;
        flags_o.ovf   = ovf_i;
      end
      FN_AND, FN_XOR: begin
        res_o = bits_i;
      end
      default: begin
        bad_fn_o = 1'b1;
      end
    endcase
    flags_o.zero = ~|res_o;
  end

endmodule

// File: rtl/alu4_core.sv
module alu4_core #(
  parameter int unsigned W  = alu4_pkg::WORD_W,
  parameter int unsigned FW = alu4_pkg::FN_W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [FW-1:0] fn_i,
  output logic [W-1:0]  res_o,
  output logic          zf_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          bad_fn_o
);
  import alu4_pkg::*;

  // Named internal events, visible to the bound checker.
  logic                sel_sub;
  logic                sel_xor;
  logic [W-1:0]        arith_sum;
  logic                arith_carry;
  logic                arith_ovf;
  logic [W-1:0]        logic_out;
  alu_flags_t          flags;

  assign sel_sub = (fn_i == FN_SUB);
  assign sel_xor = (fn_i == FN_XOR);

  alu4_arith #(.W(W)) u_arith (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sel_sub),
    .sum_o   (arith_sum),
    .carry_o (arith_carry),
    .ovf_o   (arith_ovf)
  );

  alu4_logic #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .xor_i (sel_xor),
    .out_o (logic_out)
  );

  alu4_select #(.W(W), .FW(FW)) u_select (
    .fn_i     (fn_i),
    .sum_i    (arith_sum),
    .carry_i  (arith_carry),
    .ovf_i    (arith_ovf),
    .bits_i   (logic_out),
    .res_o    (res_o),
    .flags_o  (flags),
    .bad_fn_o (bad_fn_o)
  );

  assign zf_o = flags.zero;
  assign cf_o = flags.carry;
  assign of_o = flags.ovf;

endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
  parameter int unsigned W  = alu4_pkg::WORD_W,
  parameter int unsigned FW = alu4_pkg::FN_W
) (
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [FW-1:0] fn_i,
  input logic [W-1:0]  res_o,
  input logic          zf_o,
  input logic          cf_o,
  input logic          of_o,
  input logic          bad_fn_o,
  input logic [W-1:0]  arith_sum,
  input logic          arith_carry
);

  always_comb begin
    // R10
    bad_fn_zero_chk: assert (!bad_fn_o || (res_o == '0 && zf_o && !cf_o && !of_o))
      else $error("bad selector did not clear outputs");
    // R9
    logic_no_flags_chk: assert (!(fn_i == 4'd2 || fn_i == 4'd3) || (!cf_o && !of_o))
      else $error("logic op raised carry/overflow");
    // R7
    sub_borrow_chk: assert (fn_i != 4'd1 || (arith_carry == (b_i < a_i)))
      else $error("borrow disagrees with unsigned compare");
    // R7
    add_wrap_chk: assert (fn_i != 4'd0 || (arith_carry == (arith_sum < a_i)))
      else $error("add carry disagrees with wrap");
    // R8
    add_ovf_sign_chk: assert (fn_i != 4'd0 || !of_o || (res_o[W-1] != a_i[W-1]))
      else $error("add overflow without sign change");
    // R6
    xor_zero_equal_chk: assert (fn_i != 4'd3 || (zf_o == (a_i == b_i)))
      else $error("xor zero flag disagrees with operand equality");
  end

endmodule

bind alu4_core alu4_core_chk #(.W(W), .FW(FW)) u_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .fn_i        (fn_i),
  .res_o       (res_o),
  .zf_o        (zf_o),
  .cf_o        (cf_o),
  .of_o        (of_o),
  .bad_fn_o    (bad_fn_o),
  .arith_sum   (arith_sum),
  .arith_carry (arith_carry)
);

// File: tb/alu4_core_bench.sv
`timescale 1ns/1ps
module alu4_core_bench;

  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  fn;
  logic [31:0] res;
  logic        zf, cf, of, bad;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  logic [31:0] corners [8];

  always #5 clk = ~clk;

  alu4_core u_alu4_core (
    .a_i(a), .b_i(b), .fn_i(fn),
    .res_o(res), .zf_o(zf), .cf_o(cf), .of_o(of), .bad_fn_o(bad)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s fn=%0d a=%h b=%h: actual=%h expected=%h", req, fn, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ta, input logic [31:0] tb, input logic [3:0] tf);
    logic signed [33:0] s;
    logic [32:0]        u;
    logic [31:0]        er;
    logic               ec, eo, eb;
    a = ta; b = tb; fn = tf;
    #1; // R1: no clock edge between drive and sample
    ec = 1'b0; eo = 1'b0; eb = 1'b0; er = 32'd0;
    case (tf)
      4'd0: begin
        u  = {1'b0, ta} + {1'b0, tb};
        s  = $signed({{2{ta[31]}}, ta}) + $signed({{2{tb[31]}}, tb});
        er = u[31:0]; ec = u[32];
        eo = (s > 34'sd2147483647) || (s < -34'sd2147483648);
        chk("R2", res, er);
      end
      4'd1: begin
        s  = $signed({{2{tb[31]}}, tb}) - $signed({{2{ta[31]}}, ta});
        er = tb - ta; ec = (tb < ta);
        eo = (s > 34'sd2147483647) || (s < -34'sd2147483648);
        chk("R3", res, er);
      end
      4'd2: begin er = ta & tb; chk("R4", res, er); chk("R9", {30'd0, cf, of}, 32'd0); end
      4'd3: begin er = ta ^ tb; chk("R5", res, er); chk("R9", {30'd0, cf, of}, 32'd0); end
      default: begin
        eb = 1'b1;
        chk("R10", {28'd0, res == 32'd0, zf, cf, of}, 32'hC);
      end
    endcase
    chk("R6", {31'd0, zf}, {31'd0, er == 32'd0});
    chk("R7", {31'd0, cf}, {31'd0, ec});
    chk("R8", {31'd0, of}, {31'd0, eo});
    chk("R10", {31'd0, bad}, {31'd0, eb});
    #1;
  endtask

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000; corners[5] = 32'h8000_0001;
    corners[6] = 32'h5555_AAAA; corners[7] = 32'h0001_0000;
    a = '0; b = '0; fn = '0;
    #2;
    // R1: settled value with all-zero inputs, before any clock-driven activity matters
    chk("R1", res, 32'd0);
    chk("R6", {31'd0, zf}, 32'd1);
    // Spot cases: R2 wrap, R3 operand order, R8 boundaries
    apply(32'hFFFF_FFFF, 32'h1, 4'd0);   // R2 wraps to 0, carry set
    apply(32'd5, 32'd3, 4'd1);           // R3 3-5 borrows
    apply(32'h1, 32'h8000_0000, 4'd1);   // R8 min-1 overflows
    apply(32'h7FFF_FFFF, 32'h1, 4'd0);   // R8 max+1 overflows
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply(corners[i], corners[j], f[3:0]);
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      for (int f = 0; f < 16; f++) apply(ra, rb, f[3:0]);
      apply(ra, ra, 4'd1);
      apply(ra, ra, 4'd3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule